// File: doc/BRIEF.md
# Integer Execute Unit with Zero-Anchored Register File

This block computes results for integer operations on 32-bit words: the register-immediate ones, the register-register ones and the two upper-immediate forms. It holds a 32-entry register file with two combinational read ports and one write port that commits on the clock. Index zero always reads as zero, and writes to it are dropped. Each cycle the caller supplies an operation code, two source indices, a destination index, a 12-bit immediate, a 20-bit upper immediate, the current program counter and a write request. The block returns the result combinationally. On the next rising clock edge it writes the result into the destination register when the gated write enable is high.

The second operand is either the register named by the second source index or the sign-extended 12-bit immediate, chosen by a select input. Shift operations use only the low five bits of that operand. Arithmetic wraps modulo 2^32 and raises no flag.

Top module: `int_exec_unit`

## Requirements
- R1: Operation codes on op_i: 0 add, 1 subtract, 2 signed less-than, 3 unsigned less-than, 4 and, 5 or, 6 xor, 7 shift left, 8 logical shift right, 9 arithmetic shift right, 10 load upper, 11 upper plus PC. Any other code gives a result of zero.
- R2: Add and subtract wrap modulo 2^32, with no overflow indication.
- R3: When use_imm_i is 1, the second operand is imm_i sign-extended from bit 11 to 32 bits. When it is 0, the second operand is the register at rs2_idx_i.
- R4: Signed less-than gives 1 when the first operand is below the second in two's complement, and 0 otherwise.
- R5: Unsigned less-than compares both operands as unsigned 32-bit values, after any immediate has been sign-extended, and gives 1 or 0.
- R6: And, or and xor act bitwise on the two operands.
- R7: All shifts use only bits 4:0 of the second operand as the shift amount.
- R8: Logical right shift fills with zeros. Arithmetic right shift fills with bit 31 of the first operand.
- R9: Load upper gives uimm_i in bits 31:12 and zeros in bits 11:0.
- R10: Upper plus PC gives pc_i plus the load-upper constant, modulo 2^32.
- R11: Register index 0 always reads as zero. wr_en_o is low whenever rd_idx_i is 0, so a write to index 0 has no effect.
- R12: When wr_req_i is 1 and rd_idx_i is non-zero, result_o is stored at rd_idx_i on the rising clock edge. With wr_req_i at 0 nothing is stored. Reset clears every register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 4 | Operation code |
| use_imm_i | input | 1 | Take the second operand from imm_i |
| rs1_idx_i | input | 5 | First source register index |
| rs2_idx_i | input | 5 | Second source register index |
| rd_idx_i | input | 5 | Destination register index |
| imm_i | input | 12 | Signed immediate |
| uimm_i | input | 20 | Upper immediate |
| pc_i | input | 32 | Current program counter |
| wr_req_i | input | 1 | Request to write the result |
| result_o | output | 32 | Combinational result |
| wr_en_o | output | 1 | Gated write enable |

## Verification
The hardest cases to reach are operands near the signed and unsigned boundaries, such as 0x80000000, 0x7FFFFFFF and all-ones, because no register holds them until the bench builds them through the block itself. The stimulus starts from reset-zero registers and uses load-upper and add-immediate writes to place these values. It then applies the compare, wrap and shift vectors to them, including shift operands whose upper bits are set, to show that only the low five bits count. Writes to index zero and writes with the request held low are followed by reads of the same register to show that nothing was stored.

// File: rtl/rv_exec_pkg.sv
package rv_exec_pkg;
  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_SLT   = 4'd2,
    OP_SLTU  = 4'd3,
    OP_AND   = 4'd4,
    OP_OR    = 4'd5,
    OP_XOR   = 4'd6,
    OP_SLL   = 4'd7,
    OP_SRL   = 4'd8,
    OP_SRA   = 4'd9,
    OP_LUI   = 4'd10,
    OP_AUIPC = 4'd11
  } exec_op_e;
endpackage

// File: rtl/exec_regfile.sv
module exec_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int IW = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [IW-1:0]   ra_idx_i,
  input  logic [IW-1:0]   rb_idx_i,
  output logic [XLEN-1:0] ra_data_o,
  output logic [XLEN-1:0] rb_data_o,
  input  logic            we_i,
  input  logic [IW-1:0]   wr_idx_i,
  input  logic [XLEN-1:0] wr_data_i
);
  logic [XLEN-1:0] regs [NREG];

  assign regs[0] = '0;

  for (genvar g = 1; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              regs[g] <= '0;
      else if (we_i && wr_idx_i == IW'(g))      regs[g] <= wr_data_i;
    end
  end

  assign ra_data_o = regs[ra_idx_i];
  assign rb_data_o = regs[rb_idx_i];

  // R11
  x0_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ra_idx_i == '0) |-> (ra_data_o == '0));

  // R12
  wr_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(we_i) && $past(wr_idx_i) != '0 && ra_idx_i == $past(wr_idx_i))
      |-> (ra_data_o == $past(wr_data_i)));
endmodule

// File: rtl/exec_opnd.sv
module exec_opnd #(
  parameter int XLEN   = 32,
  parameter int IMM_W  = 12,
  parameter int UIMM_W = 20
) (
  input  logic [XLEN-1:0]   rs2_val_i,
  input  logic              use_imm_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [UIMM_W-1:0] uimm_i,
  output logic [XLEN-1:0]   opnd_b_o,
  output logic [XLEN-1:0]   upper_o
);
  logic [XLEN-1:0] imm_sx;

  assign imm_sx   = {{(XLEN-IMM_W){imm_i[IMM_W-1]}}, imm_i};
  assign opnd_b_o = use_imm_i ? imm_sx : rs2_val_i;
  assign upper_o  = {uimm_i, {(XLEN-UIMM_W){1'b0}}};
endmodule

// File: rtl/exec_alu.sv
module exec_alu
  import rv_exec_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [3:0]      op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [XLEN-1:0] upper_i,
  input  logic [XLEN-1:0] pc_i,
  output logic [XLEN-1:0] res_o
);
  logic [SHW-1:0]  shamt;
  logic            lt_s, lt_u;

  assign shamt = b_i[SHW-1:0];
  assign lt_s  = $signed(a_i) < $signed(b_i);
  assign lt_u  = a_i < b_i;

  always_comb begin
    unique case (exec_op_e'(op_i))
      OP_ADD:   res_o = a_i + b_i;
      OP_SUB:   res_o = a_i - b_i;
      OP_SLT:   res_o = XLEN'(lt_s);
      OP_SLTU:  res_o = XLEN'(lt_u);
      OP_AND:   res_o = a_i & b_i;
      OP_OR:    res_o = a_i | b_i;
      OP_XOR:   res_o = a_i ^ b_i;
      OP_SLL:   res_o = a_i << shamt;
      OP_SRL:   res_o = a_i >> shamt;
      OP_SRA:   res_o = $unsigned($signed(a_i) >>> shamt);
      OP_LUI:   res_o = upper_i;
      OP_AUIPC: res_o = pc_i + upper_i;
      default:  res_o = '0;
    endcase
  end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import rv_exec_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int NREG   = 32,
  parameter int IMM_W  = 12,
  parameter int UIMM_W = 20,
  localparam int IW    = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        op_i,
  input  logic              use_imm_i,
  input  logic [IW-1:0]     rs1_idx_i,
  input  logic [IW-1:0]     rs2_idx_i,
  input  logic [IW-1:0]     rd_idx_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [UIMM_W-1:0] uimm_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              wr_req_i,
  output logic [XLEN-1:0]   result_o,
  output logic              wr_en_o
);
  logic [XLEN-1:0] rs1_val, rs2_val, opnd_b, upper;

  exec_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ra_idx_i  (rs1_idx_i),
    .rb_idx_i  (rs2_idx_i),
    .ra_data_o (rs1_val),
    .rb_data_o (rs2_val),
    .we_i      (wr_en_o),
    .wr_idx_i  (rd_idx_i),
    .wr_data_i (result_o)
  );

  exec_opnd #(.XLEN(XLEN), .IMM_W(IMM_W), .UIMM_W(UIMM_W)) u_opnd (
    .rs2_val_i (rs2_val),
    .use_imm_i (use_imm_i),
    .imm_i     (imm_i),
    .uimm_i    (uimm_i),
    .opnd_b_o  (opnd_b),
    .upper_o   (upper)
  );

  exec_alu #(.XLEN(XLEN)) u_alu (
    .op_i    (op_i),
    .a_i     (rs1_val),
    .b_i     (opnd_b),
    .upper_i (upper),
    .pc_i    (pc_i),
    .res_o   (result_o)
  );

  // index 0 is never a legal write target
  assign wr_en_o = wr_req_i && (rd_idx_i != '0);

  // R11
  x0_write_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_idx_i == '0) |-> !wr_en_o);

  // R4
  slt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_SLT || op_i == OP_SLTU) |-> (result_o[XLEN-1:1] == '0));

  // R9
  lui_low_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_LUI) |-> (result_o[XLEN-UIMM_W-1:0] == '0));

  // R8
  srl_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_SRL && opnd_b[$clog2(XLEN)-1:0] != '0) |-> !result_o[XLEN-1]);

  // R8
  sra_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_SRA) |-> (result_o[XLEN-1] == rs1_val[XLEN-1]));
endmodule

// File: tb/tb_int_exec_unit.sv
module tb_int_exec_unit;
  typedef struct packed {
    logic [23:0] tag;
    logic [3:0]  op;
    logic        sel;
    logic [4:0]  a;
    logic [4:0]  b;
    logic [4:0]  d;
    logic        wr;
    logic [11:0] imm;
    logic [19:0] uimm;
    logic [31:0] pc;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 38;
  localparam vec_t VECS [NV] = '{
    '{"R12", 4'd0,  1'b0, 5'd1, 5'd2, 5'd0, 1'b0, 12'h000, 20'h00000, 32'h0, 32'h0000_0000}, // reset zero
    '{"R9 ", 4'd10, 1'b0, 5'd0, 5'd0, 5'd1, 1'b1, 12'h000, 20'h80000, 32'h0, 32'h8000_0000}, // x1
    '{"R3 ", 4'd0,  1'b1, 5'd0, 5'd0, 5'd2, 1'b1, 12'hFFF, 20'h00000, 32'h0, 32'hFFFF_FFFF}, // x2
    '{"R9 ", 4'd10, 1'b0, 5'd0, 5'd0, 5'd3, 1'b1, 12'h000, 20'h80000, 32'h0, 32'h8000_0000},
    '{"R2 ", 4'd0,  1'b1, 5'd3, 5'd0, 5'd3, 1'b1, 12'hFFF, 20'h00000, 32'h0, 32'h7FFF_FFFF}, // x3
    '{"R3 ", 4'd0,  1'b1, 5'd0, 5'd0, 5'd4, 1'b1, 12'h123, 20'h00000, 32'h0, 32'h0000_0123}, // x4
    '{"R3 ", 4'd0,  1'b1, 5'd0, 5'd0, 5'd5, 1'b1, 12'h025, 20'h00000, 32'h0, 32'h0000_0025}, // x5
    '{"R2 ", 4'd0,  1'b0, 5'd3, 5'd4, 5'd0, 1'b0, 12'h000, 20'h00000, 32'h0, 32'h8000_0122},
    '{"R2 ", 4'd0,  1'b0, 5'd2, 5'd4, 5'd0, 1'b0, 12'h000, 20'h00000, 32'h0, 32'h0000_0122},
    '{"R2 ", 4'd1,  1'b0, 5'd4, 5'd2, 5'd0, 1'b0, 12'h000, 20'h00000, 32'h0, 32'h0000_0124},
    '{"R2 ", 4'd1,  1'b0, 5'd0, 5'd4, 5'd0, 1'b0, 12'h000, 20'h00000, 32'h0, 32'hFFFF_FEDD},
    '{"R3 ", 4'd0,  1'b1, 5'd4, 5'd0, 5'd0, 1'b0, 12'h800, 20'h00000, 32'h0, 32'hFFFF_F923},
    '{"R4 ", 4'd2,  1'b0, 5'd1, 5'd4, 5'd0, 1'b0, 12'h000, 20'h00000, 32'h0, 32'h0000_0001},
    '{"R4 ", 4'd2,  1'b0, 5'd4, 5'd1, 5'd0, 1'b0, 12'h000, 20'h00000, 32'h0, 32'h0000_0000},
    '{"R4 ", 4'd2,  1'b1, 5'd4, 5'd0, 5'd0, 1'b0, 12'hFFF, 20'h00000, 32'h0, 32'h0000_0000},
    '{"R5 ", 4'd3,  1'b0, 5'd4, 5'd1, 5'd0, 1'b0, 12'h000, 20'h00000, 32'h0, 32'h0000_0001},
    '{"R5 ", 4'd3,  1'b0, 5'd2, 5'd1, 5'd0, 1'b0, 12'h000, 20'h00000, 32'h0, 32'h0000_0000},
    '{"R5 ", 4'd3,  1'b1, 5'd4, 5'd0, 5'd0, 1'b0, 12'hFFF, 20'h00000, 32'h0, 32'h0000_0001},
    '{"R6 ", 4'd4,  1'b0, 5'd2, 5'd4, 5'd0, 1'b0, 12'h000, 20'h00000, 32'h0, 32'h0000_0123},
    '{"R6 ", 4'd5,  1'b0, 5'd1, 5'd4, 5'd0, 1'b0, 12'h000, 20'h00000, 32'h0, 32'h8000_0123},
    '{"R6 ", 4'd6,  1'b0, 5'd3, 5'd2, 5'd0, 1'b0, 12'h000, 20'h00000, 32'h0, 32'h8000_0000},
    '{"R6 ", 4'd6,  1'b1, 5'd4, 5'd0, 5'd0, 1'b0, 12'hFFF, 20'h00000, 32'h0, 32'hFFFF_FEDC},
    '{"R6 ", 4'd4,  1'b1, 5'd2, 5'd0, 5'd0, 1'b0, 12'h0F0, 20'h00000, 32'h0, 32'h0000_00F0},
    '{"R6 ", 4'd5,  1'b1, 5'd0, 5'd0, 5'd0, 1'b0, 12'h555, 20'h00000, 32'h0, 32'h0000_0555},
    '{"R7 ", 4'd7,  1'b0, 5'd4, 5'd5, 5'd0, 1'b0, 12'h000, 20'h00000, 32'h0, 32'h0000_2460},
    '{"R8 ", 4'd8,  1'b0, 5'd1, 5'd5, 5'd0, 1'b0, 12'h000, 20'h00000, 32'h0, 32'h0400_0000},
    '{"R8 ", 4'd9,  1'b0, 5'd1, 5'd5, 5'd0, 1'b0, 12'h000, 20'h00000, 32'h0, 32'hFC00_0000},
    '{"R8 ", 4'd9,  1'b0, 5'd3, 5'd5, 5'd0, 1'b0, 12'h000, 20'h00000, 32'h0, 32'h03FF_FFFF},
    '{"R8 ", 4'd9,  1'b1, 5'd1, 5'd0, 5'd0, 1'b0, 12'h01F, 20'h00000, 32'h0, 32'hFFFF_FFFF},
    '{"R7 ", 4'd8,  1'b1, 5'd1, 5'd0, 5'd0, 1'b0, 12'h03F, 20'h00000, 32'h0, 32'h0000_0001},
    '{"R9 ", 4'd10, 1'b0, 5'd0, 5'd0, 5'd0, 1'b0, 12'hFFF, 20'hABCDE, 32'h0, 32'hABCD_E000},
    '{"R10", 4'd11, 1'b0, 5'd0, 5'd0, 5'd0, 1'b0, 12'h000, 20'h00001, 32'h0000_1234, 32'h0000_2234},
    '{"R10", 4'd11, 1'b0, 5'd0, 5'd0, 5'd0, 1'b0, 12'h000, 20'h00002, 32'hFFFF_F000, 32'h0000_1000},
    '{"R11", 4'd0,  1'b1, 5'd0, 5'd0, 5'd0, 1'b1, 12'h005, 20'h00000, 32'h0, 32'h0000_0005},
    '{"R11", 4'd0,  1'b0, 5'd0, 5'd0, 5'd0, 1'b0, 12'h000, 20'h00000, 32'h0, 32'h0000_0000},
    '{"R12", 4'd0,  1'b1, 5'd0, 5'd0, 5'd6, 1'b0, 12'h007, 20'h00000, 32'h0, 32'h0000_0007},
    '{"R12", 4'd0,  1'b0, 5'd6, 5'd0, 5'd0, 1'b0, 12'h000, 20'h00000, 32'h0, 32'h0000_0000},
    '{"R1 ", 4'd15, 1'b0, 5'd3, 5'd4, 5'd0, 1'b0, 12'h000, 20'h00000, 32'h0, 32'h0000_0000}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  op_i = '0;
  logic        use_imm_i = 1'b0;
  logic [4:0]  rs1_idx_i = '0, rs2_idx_i = '0, rd_idx_i = '0;
  logic [11:0] imm_i = '0;
  logic [19:0] uimm_i = '0;
  logic [31:0] pc_i = '0;
  logic        wr_req_i = 1'b0;
  logic [31:0] result_o;
  logic        wr_en_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  int_exec_unit dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .use_imm_i(use_imm_i),
    .rs1_idx_i(rs1_idx_i), .rs2_idx_i(rs2_idx_i), .rd_idx_i(rd_idx_i),
    .imm_i(imm_i), .uimm_i(uimm_i), .pc_i(pc_i), .wr_req_i(wr_req_i),
    .result_o(result_o), .wr_en_o(wr_en_o)
  );

  task automatic apply(input vec_t v);
    logic exp_we;
    @(negedge clk_i);
    op_i = v.op; use_imm_i = v.sel; rs1_idx_i = v.a; rs2_idx_i = v.b;
    rd_idx_i = v.d; wr_req_i = v.wr; imm_i = v.imm; uimm_i = v.uimm; pc_i = v.pc;
    #2;
    exp_we = v.wr && (v.d != 0);
    n_chk++;
    if (result_o !== v.exp || wr_en_o !== exp_we) begin
      n_bad++;
      $display("FAIL %s: op=%0d result=%h/%b expected=%h/%b", v.tag, v.op,
               result_o, wr_en_o, v.exp, exp_we);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) apply(VECS[i]);
    // R12: reset clears written registers (x3 = 0x7FFFFFFF, x4 = 0x123)
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    apply('{"R12", 4'd0, 1'b0, 5'd3, 5'd4, 5'd0, 1'b0, 12'h0, 20'h0, 32'h0, 32'h0});
    // R11: write request to x0 leaves wr_en_o low, x0 still reads zero
    apply('{"R11", 4'd10, 1'b0, 5'd0, 5'd0, 5'd0, 1'b1, 12'h0, 20'hFFFFF, 32'h0, 32'hFFFF_F000});
    apply('{"R11", 4'd5, 1'b0, 5'd0, 5'd0, 5'd0, 1'b0, 12'h0, 20'h0, 32'h0, 32'h0});
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule